// File: doc/BRIEF.md
# Real-Time Clock Core with Update-Warning Flag

This block keeps calendar time as a chain of counters: seconds, minutes, hours, day of month, month and a two-digit year. A day-of-week counter advances together with the day of month. Once per second a carry ripples up the chain, one field per clock cycle. While it moves, the fields disagree with one another for a few cycles. To guard software against this, the core raises an update-warning flag a fixed number of cycles before the ripple starts. The flag drops in the same cycle that the ripple finishes, and that cycle also sets an update-done event flag. The event flag can drive an interrupt pin.

Software uses a plain register port. A read registers its data, and the data is valid one cycle after the request. Reads and writes are always accepted and never stall. No streamed data passes this block, so there is no back-pressure. Software has two safe ways to read the time. It can read the warning flag and then complete its reads within the lead window. It can also take the update-done interrupt and read during the stable part of the second that follows. In a third option, a buffered mode returns the time registers from a snapshot that is reloaded only once an update has settled. The second length and the lead time are parameters counted in clock cycles, and the second must exceed the lead time plus six cycles.

Top module: `rtc_core`

## Requirements
- R1: After reset the fields read as follows. Seconds, minutes, hours and year read 0. Day of week, day of month and month read 1. Control, status low bits and the event flag read 0. The event-flag read (address 0xC) issued in the first cycle returns 0.
- R2: The time fields sit at these addresses: seconds 0x0, minutes 0x2, hours 0x4, day of month 0x7, month 0x8 and year 0x9, with ranges 0–59, 0–59, 0–23, per month, 1–12 and 0–99. Seconds advance once every CYC_PER_SEC cycles. The update edge is the edge at which the phase counter equals CYC_PER_SEC-1, and it is counted from reset. On wrap, the carry reaches each higher field one cycle after the field below it. A year of 99 wraps to 0.
- R3: The day of month wraps after 30 in months 4, 6, 9 and 11, after 28 in month 2, and after 29 in month 2 when the year is divisible by 4. In every other month it wraps after 31. The day of week at 0x6 counts 1 to 7 and steps whenever the day of month steps.
- R4: The warning flag is bit 7 of address 0xA. It sets LEAD_CYC cycles before the seconds field changes. No field changes while the flag is set before the ripple.
- R5: The warning flag clears at the same edge that the year stage of the ripple completes, five cycles after seconds change. At that edge the event flag (bit 7 of 0xC) sets.
- R6: A read of 0xC returns the event flag and clears it. When a completion and such a read fall in one cycle, the flag stays set.
- R7: irq_o is high exactly when the event flag is set and control bit 0 (interrupt enable, address 0xB) is 1.
- R8: When control bit 1 is 1 (buffered mode), time reads return a snapshot. The snapshot is reloaded from the live fields one cycle after each update completes. Writes to the live fields do not show up in reads until that reload.
- R9: Bits 6:0 of 0xA are plain read/write storage. A write to bit 7 of 0xA is ignored.
- R10: A read of 0xD returns 0x80. A read of 0x1, 0x3, 0x5, 0xE or 0xF returns 0.
- R11: rdata takes the selected value at the edge where rd_en is high and holds it while rd_en is low.
- R12: A field whose value is at or above its upper limit wraps to its lower limit at its next increment and carries upward.
- R13: A write to a field at the edge where that field would step stores the written value. The carry still comes from the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| irq_o | output | 1 | Update-done interrupt |

## Verification
Read data appears one cycle after rd_en. The warning flag rises at the edge after the phase counter reaches CYC_PER_SEC-1-LEAD_CYC. Seconds step at the edge where the phase equals CYC_PER_SEC-1, and each higher field steps one edge later than the one below. The flag clears and the event flag sets at the phase-4 edge. The buffered snapshot reloads at the phase-5 edge. The bench model counts the same phase from reset. It compares rdata and irq_o on the falling edge after every rising edge, so each result is sampled in the cycle it becomes due. The directed reads are placed at named phases to hit the boundary edges: the flag-setting edge, the ripple edges, the completion edge and the reload edge.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int RTC_DW   = 8;
  localparam int RTC_AW   = 4;
  localparam int N_CHAIN  = 6;          // sec, min, hour, day, month, year
  localparam int N_TIME   = N_CHAIN + 1; // plus weekday
  localparam int IDX_DAY  = 3;
  localparam int IDX_MON  = 4;
  localparam int IDX_YR   = 5;
  localparam int IDX_WDAY = 6;
  localparam int TOP_BIT  = RTC_DW - 1;
  localparam int CTRL_IE  = 0;
  localparam int CTRL_BUF = 1;

  typedef logic [RTC_DW-1:0] byte_t;
  typedef logic [RTC_AW-1:0] addr_t;

  localparam addr_t A_STAT  = addr_t'(4'hA);
  localparam addr_t A_CTRL  = addr_t'(4'hB);
  localparam addr_t A_FLAG  = addr_t'(4'hC);
  localparam addr_t A_VALID = addr_t'(4'hD);

  function automatic addr_t time_addr(input int idx);
    case (idx)
      0:        return addr_t'(4'h0);
      1:        return addr_t'(4'h2);
      2:        return addr_t'(4'h4);
      IDX_DAY:  return addr_t'(4'h7);
      IDX_MON:  return addr_t'(4'h8);
      IDX_YR:   return addr_t'(4'h9);
      default:  return addr_t'(4'h6);
    endcase
  endfunction

  function automatic byte_t lo_lim(input int idx);
    if (idx == IDX_DAY || idx == IDX_MON || idx == IDX_WDAY) return byte_t'(1);
    return byte_t'(0);
  endfunction

  function automatic byte_t hi_lim(input int idx);
    case (idx)
      0, 1:     return byte_t'(59);
      2:        return byte_t'(23);
      IDX_DAY:  return byte_t'(31);
      IDX_MON:  return byte_t'(12);
      IDX_YR:   return byte_t'(99);
      default:  return byte_t'(7);
    endcase
  endfunction

  function automatic byte_t month_len(input byte_t mon, input byte_t yr);
    case (mon)
      byte_t'(2):                                    return (yr[1:0] == 2'b00) ? byte_t'(29) : byte_t'(28);
      byte_t'(4), byte_t'(6), byte_t'(9), byte_t'(11): return byte_t'(30);
      default:                                       return byte_t'(31);
    endcase
  endfunction
endpackage

// File: rtl/rtc_timebase.sv
// Phase counter for one second, the ripple-stage strobes and the warning flag.
module rtc_timebase #(
  parameter int CYC_PER_SEC = 40,
  parameter int LEAD_CYC    = 8,
  parameter int NSTG        = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [NSTG-1:0] step_o,
  output logic            done_o,
  output logic            uip_o
);
  localparam int PW     = (CYC_PER_SEC > 2) ? $clog2(CYC_PER_SEC) : 1;
  localparam int UIP_AT = CYC_PER_SEC - 1 - LEAD_CYC;
  localparam int LAST   = CYC_PER_SEC - 1;

  logic [PW-1:0] ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                  ph_q <= '0;
    else if (ph_q == PW'(LAST))  ph_q <= '0;
    else                         ph_q <= ph_q + 1'b1;
  end

  // stage k fires k cycles after the seconds stage
  for (genvar k = 0; k < NSTG; k++) begin : g_stp
    assign step_o[k] = (ph_q == PW'((LAST + k) % CYC_PER_SEC));
  end

  assign done_o = step_o[NSTG-1];

  always_ff @(posedge clk) begin
    if (!rst_n)                    uip_o <= 1'b0;
    else if (ph_q == PW'(UIP_AT))  uip_o <= 1'b1;
    else if (done_o)               uip_o <= 1'b0;
  end
endmodule

// File: rtl/rtc_field.sv
// One wrap-around counter of the carry chain.
module rtc_field
  import rtc_pkg::*;
#(
  parameter byte_t RST_VAL = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step,
  input  logic  inc,
  input  byte_t lo,
  input  byte_t hi,
  input  logic  wr,
  input  byte_t wdata,
  output byte_t val,
  output logic  carry
);
  logic at_top;
  assign at_top = (val >= hi);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val   <= RST_VAL;
      carry <= 1'b0;
    end else begin
      if (step)             carry <= inc && at_top;
      if (wr)               val   <= wdata;
      else if (step && inc) val   <= at_top ? lo : val + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int CYC_PER_SEC = 40,
  parameter int LEAD_CYC    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [RTC_AW-1:0] addr,
  input  logic [RTC_DW-1:0] wdata,
  output logic [RTC_DW-1:0] rdata,
  output logic              irq_o
);
  logic [N_CHAIN-1:0] step;
  logic               done;
  logic               uip;
  byte_t              live [N_TIME];
  byte_t              hold [N_TIME];
  logic [N_TIME-1:0]  cy;
  byte_t              day_hi;
  logic               buf_mode, irq_en, hold_ld_q, ue_flag_q;
  logic [TOP_BIT-1:0] stat_lo;
  byte_t              rd_mux;

  rtc_timebase #(
    .CYC_PER_SEC(CYC_PER_SEC),
    .LEAD_CYC   (LEAD_CYC),
    .NSTG       (N_CHAIN)
  ) u_tb (
    .clk   (clk),
    .rst_n (rst_n),
    .step_o(step),
    .done_o(done),
    .uip_o (uip)
  );

  assign day_hi = month_len(live[IDX_MON], live[IDX_YR]);

  for (genvar k = 0; k < N_TIME; k++) begin : g_fld
    logic  stp, inc;
    byte_t hi;
    if (k == 0) begin : g_sec
      assign stp = step[0];
      assign inc = 1'b1;
      assign hi  = hi_lim(0);
    end else if (k == IDX_WDAY) begin : g_wday
      assign stp = step[IDX_DAY];
      assign inc = cy[IDX_DAY-1];
      assign hi  = hi_lim(k);
    end else if (k == IDX_DAY) begin : g_day
      assign stp = step[k];
      assign inc = cy[k-1];
      assign hi  = day_hi;
    end else begin : g_mid
      assign stp = step[k];
      assign inc = cy[k-1];
      assign hi  = hi_lim(k);
    end
    rtc_field #(.RST_VAL(lo_lim(k))) u_fld (
      .clk  (clk),
      .rst_n(rst_n),
      .step (stp),
      .inc  (inc),
      .lo   (lo_lim(k)),
      .hi   (hi),
      .wr   (wr_en && (addr == time_addr(k))),
      .wdata(wdata),
      .val  (live[k]),
      .carry(cy[k])
    );

    // snapshot: follows live when unbuffered, reloads after each update otherwise
    always_ff @(posedge clk) begin
      if (!rst_n)                     hold[k] <= lo_lim(k);
      else if (!buf_mode || hold_ld_q) hold[k] <= live[k];
    end
  end

  logic unused_cy;
  assign unused_cy = ^cy[N_TIME-1:N_CHAIN-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_lo   <= '0;
      irq_en    <= 1'b0;
      buf_mode  <= 1'b0;
      ue_flag_q <= 1'b0;
      hold_ld_q <= 1'b0;
    end else begin
      hold_ld_q <= done;
      if (wr_en && addr == A_STAT) stat_lo <= wdata[TOP_BIT-1:0];
      if (wr_en && addr == A_CTRL) begin
        irq_en   <= wdata[CTRL_IE];
        buf_mode <= wdata[CTRL_BUF];
      end
      if (done)                          ue_flag_q <= 1'b1;
      else if (rd_en && addr == A_FLAG)  ue_flag_q <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_STAT:  rd_mux = {uip, stat_lo};
      A_CTRL:  begin
        rd_mux[CTRL_IE]  = irq_en;
        rd_mux[CTRL_BUF] = buf_mode;
      end
      A_FLAG:  rd_mux[TOP_BIT] = ue_flag_q;
      A_VALID: rd_mux[TOP_BIT] = 1'b1;
      default: ;
    endcase
    for (int k = 0; k < N_TIME; k++) begin
      if (addr == time_addr(k)) rd_mux = buf_mode ? hold[k] : live[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  assign irq_o = ue_flag_q & irq_en;
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic [3:0] addr,
  input logic [7:0] rdata,
  input logic       irq_o,
  input logic       uip,
  input logic       ue_flag,
  input logic       done,
  input logic [7:0] sec
);
  // R4
  uip_lead_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(uip) && !wr_en) |=> $stable(sec));

  // R2
  sec_moves_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sec) && !$past(wr_en)) |-> uip);

  // R5
  uip_ends_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uip) |-> ue_flag);

  // R6
  flag_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 4'hC && !done) |=> !ue_flag);

  // R7
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ue_flag);

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  // R10
  valid_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 4'hD) |=> (rdata == 8'h80));
endmodule

bind rtc_core rtc_core_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .wr_en  (wr_en),
  .rd_en  (rd_en),
  .addr   (addr),
  .rdata  (rdata),
  .irq_o  (irq_o),
  .uip    (uip),
  .ue_flag(ue_flag_q),
  .done   (done),
  .sec    (live[0])
);

// File: tb/tb_rtc_core.sv
module tb_rtc_core;
  localparam int P = 40;
  localparam int LD = 8;
  localparam int UIP_AT = P - 1 - LD;
  localparam int WDOG = 100000;

  logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  wire  [7:0] rdata;
  wire        irq_o;

  always #5 clk = ~clk;

  rtc_core #(.CYC_PER_SEC(P), .LEAD_CYC(LD)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  int n_chk = 0, n_err = 0, cyc = 0;

  // ---------------- behavioural reference ----------------
  int m_ph, m_alow, m_rd, m_last;
  int m_f[7];
  int m_hold[7];
  bit m_car[7];
  bit m_uip, m_flag, m_ld, m_ie, m_buf;

  function automatic int tidx(input int a);
    case (a)
      0: return 0;  2: return 1;  4: return 2;  7: return 3;
      8: return 4;  9: return 5;  6: return 6;
      default: return -1;
    endcase
  endfunction

  function automatic int mlen(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic int lo_of(input int k);
    return (k == 3 || k == 4 || k == 6) ? 1 : 0;
  endfunction

  function automatic int hi_of(input int k);
    case (k)
      0, 1: return 59;
      2: return 23;
      3: return mlen(m_f[4], m_f[5]);
      4: return 12;
      5: return 99;
      default: return 7;
    endcase
  endfunction

  task automatic mreset();
    m_ph = 0; m_alow = 0; m_rd = 0; m_last = 0;
    m_uip = 0; m_flag = 0; m_ld = 0; m_ie = 0; m_buf = 0;
    for (int i = 0; i < 7; i++) begin
      m_f[i] = lo_of(i); m_hold[i] = lo_of(i); m_car[i] = 0;
    end
  endtask

  task automatic mstep();
    int stage, idx, inc, h;
    bit done;
    stage = -1;
    for (int k = 0; k < 6; k++) if (m_ph == (P - 1 + k) % P) stage = k;
    done = (stage == 5);
    if (rd_en) begin
      m_last = addr;
      idx = tidx(addr);
      if (idx >= 0) m_rd = m_buf ? m_hold[idx] : m_f[idx];
      else case (addr)
        4'hA: m_rd = (m_uip ? 128 : 0) + m_alow;
        4'hB: m_rd = (m_buf ? 2 : 0) + (m_ie ? 1 : 0);
        4'hC: m_rd = m_flag ? 128 : 0;
        4'hD: m_rd = 128;
        default: m_rd = 0;
      endcase
    end
    if (done) m_flag = 1;
    else if (rd_en && addr == 4'hC) m_flag = 0;
    if (!m_buf || m_ld) for (int i = 0; i < 7; i++) m_hold[i] = m_f[i];
    m_ld = done;
    if (stage >= 0) begin
      inc = (stage == 0) ? 1 : m_car[stage-1];
      h = hi_of(stage);
      m_car[stage] = inc && (m_f[stage] >= h);
      if (inc) begin
        m_f[stage] = (m_f[stage] >= h) ? lo_of(stage) : m_f[stage] + 1;
        if (stage == 3) m_f[6] = (m_f[6] >= 7) ? 1 : m_f[6] + 1;
      end
    end
    if (wr_en) begin
      idx = tidx(addr);
      if (idx >= 0) m_f[idx] = wdata;
      else if (addr == 4'hA) m_alow = wdata & 8'h7F;
      else if (addr == 4'hB) begin m_ie = wdata[0]; m_buf = wdata[1]; end
    end
    if (m_ph == UIP_AT) m_uip = 1;
    else if (done) m_uip = 0;
    m_ph = (m_ph + 1) % P;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) mreset();
    else mstep();
  end

  function automatic string tagof(input int a);
    if (tidx(a) >= 0) return "R2";
    case (a)
      10: return "R4";
      11: return "R8";
      12: return "R6";
      default: return "R10";
    endcase
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      n_chk++;
      if (rdata !== 8'(m_rd)) begin
        n_err++;
        $display("FAIL %s: rdata=%0h expected %0h (cycle %0d)", tagof(m_last), rdata, 8'(m_rd), cyc);
      end
      n_chk++;
      if (irq_o !== (m_flag && m_ie)) begin
        n_err++;
        $display("FAIL R7: irq_o=%0b expected %0b (cycle %0d)", irq_o, (m_flag && m_ie), cyc);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc == WDOG) begin
      n_err++; n_chk++;
      $display("FAIL R11: watchdog expired, cycles=%0d expected below %0d", cyc, WDOG);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  // ---------------- stimulus helpers (called at a falling edge) ----------------
  task automatic rd_chk(input logic [3:0] a, input int exp, input string tag);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    n_chk++;
    if (rdata !== 8'(exp)) begin
      n_err++;
      $display("FAIL %s: addr %0h read %0h expected %0h", tag, a, rdata, 8'(exp));
    end
  endtask

  task automatic wr(input logic [3:0] a, input int v);
    wr_en = 1'b1; addr = a; wdata = 8'(v);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_ph(input int n);
    while (m_ph != n) @(negedge clk);
  endtask

  task automatic irq_chk(input bit exp, input string tag);
    n_chk++;
    if (irq_o !== exp) begin
      n_err++;
      $display("FAIL %s: irq_o=%0b expected %0b", tag, irq_o, exp);
    end
  endtask

  task automatic set_date(input int y, input int mo, input int d, input int h, input int mi, input int s);
    wr(4'h9, y); wr(4'h8, mo); wr(4'h7, d); wr(4'h4, h); wr(4'h2, mi); wr(4'h0, s);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_chk(4'hC, 0, "R1"); rd_chk(4'hA, 0, "R1"); rd_chk(4'hB, 0, "R1");
    rd_chk(4'h0, 0, "R1"); rd_chk(4'h2, 0, "R1"); rd_chk(4'h4, 0, "R1");
    rd_chk(4'h6, 1, "R1"); rd_chk(4'h7, 1, "R1"); rd_chk(4'h8, 1, "R1");
    rd_chk(4'h9, 0, "R1"); irq_chk(0, "R1");

    // R4 lead window
    wait_ph(UIP_AT); rd_chk(4'hA, 8'h00, "R4");
    rd_chk(4'hA, 8'h80, "R4");
    wait_ph(P - 2); rd_chk(4'h0, 0, "R4");
    // R5 flag clears at ripple end, event flag sets
    wait_ph(3); rd_chk(4'hA, 8'h80, "R5");
    rd_chk(4'hA, 8'h80, "R5");
    rd_chk(4'hA, 8'h00, "R5");
    rd_chk(4'hC, 8'h80, "R5");
    rd_chk(4'hC, 8'h00, "R6");
    rd_chk(4'h0, 1, "R2");
    // R6 set wins over read-clear
    wait_ph(4); rd_chk(4'hC, 8'h00, "R6");
    rd_chk(4'hC, 8'h80, "R6");
    // R7 interrupt gating
    wr(4'hB, 1); irq_chk(0, "R7");
    wait_ph(5); irq_chk(1, "R7");
    rd_chk(4'hC, 8'h80, "R7"); irq_chk(0, "R7");
    wr(4'hB, 0);
    // R9 status low bits
    wr(4'hA, 8'hFF); rd_chk(4'hA, 8'h7F, "R9");
    wr(4'hA, 8'h80); rd_chk(4'hA, 8'h00, "R9");
    // R10 constant and unmapped reads
    rd_chk(4'hD, 8'h80, "R10"); rd_chk(4'h5, 0, "R10");
    rd_chk(4'hE, 0, "R10"); rd_chk(4'h1, 0, "R10");

    // R3 leap February
    wait_ph(6); set_date(24, 2, 28, 23, 59, 59);
    wait_ph(6);
    rd_chk(4'h7, 29, "R3"); rd_chk(4'h8, 2, "R3"); rd_chk(4'h4, 0, "R2");
    rd_chk(4'h2, 0, "R2"); rd_chk(4'h0, 0, "R2"); rd_chk(4'h9, 24, "R3");
    // R3 common February
    wait_ph(6); set_date(23, 2, 28, 23, 59, 59);
    wait_ph(6);
    rd_chk(4'h7, 1, "R3"); rd_chk(4'h8, 3, "R3");
    // R2 year wrap, R3 weekday wrap
    wait_ph(6); set_date(99, 12, 31, 23, 59, 59); wr(4'h6, 7);
    wait_ph(6);
    rd_chk(4'h9, 0, "R2"); rd_chk(4'h8, 1, "R2"); rd_chk(4'h7, 1, "R2");
    rd_chk(4'h6, 1, "R3");
    // R3 thirty-day month
    wait_ph(6); set_date(24, 4, 30, 23, 59, 59);
    wait_ph(6);
    rd_chk(4'h7, 1, "R3"); rd_chk(4'h8, 5, "R3"); rd_chk(4'h6, 2, "R3");
    // R12 out-of-range value
    wr(4'h2, 10); wr(4'h0, 75);
    wait_ph(6);
    rd_chk(4'h0, 0, "R12"); rd_chk(4'h2, 11, "R12");
    // R13 write on the stepping edge
    wr(4'h0, 59);
    wait_ph(P - 1); wr(4'h0, 10);
    wait_ph(6);
    rd_chk(4'h0, 10, "R13"); rd_chk(4'h2, 12, "R13");
    // R8 buffered reads
    wr(4'hB, 2); wr(4'h0, 30);
    rd_chk(4'h0, 10, "R8"); rd_chk(4'hB, 2, "R8");
    wait_ph(5); rd_chk(4'h0, 10, "R8");
    rd_chk(4'h0, 31, "R8");
    wr(4'hB, 0);

    // mixed traffic, compared each cycle by the model
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = $urandom % 8;
      if (r < 4) begin
        rd_en = 1'b1; addr = 4'($urandom);
        @(negedge clk); rd_en = 1'b0;
      end else if (r == 4) begin
        wr_en = 1'b1; addr = 4'($urandom); wdata = 8'($urandom % 110);
        @(negedge clk); wr_en = 1'b0;
      end else begin
        @(negedge clk);
      end
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule